// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block chooses the clock cycles in which a freshly computed output-driver impedance code may be applied. The code itself comes from an outside calibration loop. The block only decides when that code is copied into the register that feeds the drivers. The goal is that a code change never lands in a cycle where the data pins are being driven.

Each cycle, the host pipeline reports three things: whether the device is selected, whether the cycle is a read, and whether output-enable is inactive. An interval counter advances on every clock, whatever the cycle does. Once the minimum spacing has passed, the first cycle that leaves the outputs idle fires a one-cycle update strobe. On that same edge, the input code is captured into the driver code register.

A second counter tracks power-up settling. It counts cycles that are not reads and raises a sticky settled flag once enough of them have passed. The block also reports the nominal driver impedance that a given external resistor selects, which is one fifth of the resistor value.

Top module: `imp_upd_sched`

## Requirements
- R1: While reset is asserted, and directly after it, `drv_code` equals `RESET_CODE` (default 6'h20), `settled` is 0, and `upd_stb` is 0.
- R2: Two pulses of `upd_stb` are always at least `MIN_GAP` (default 32) cycles apart. After reset, the earliest pulse is in the `MIN_GAP`-th cycle.
- R3: `upd_stb` is never high in a cycle with `cyc_sel`=1, `cyc_read`=1 and `oe_off`=0, because such a cycle drives the outputs. Deselected cycles, write cycles and reads with `oe_off`=1 are all eligible.
- R4: The interval count advances on every clock, regardless of cycle type. With eligible cycles only, the strobe fires exactly every `MIN_GAP` cycles.
- R5: Suppose at least `MIN_GAP` cycles have passed since the last update (or since reset), for example during a long run of driving reads. Then the first eligible cycle fires `upd_stb` in that same cycle.
- R6: `drv_code` takes the value of `cal_code` at the clock edge that ends a cycle with `upd_stb`=1. At every other edge it holds its value.
- R7: `settled` rises after `SETTLE_CYCLES` (default 1024) non-read cycles. A cycle with `cyc_sel`=1 and `cyc_read`=1 is not counted, whatever the value of `oe_off`. Once high, `settled` stays high until reset.
- R8: `tgt_imp` equals `ext_res` divided by 5, rounded down. The value is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_sel | input | 1 | Current cycle selects the device |
| cyc_read | input | 1 | Current cycle is a read |
| oe_off | input | 1 | Output-enable inactive in this cycle |
| cal_code | input | CODE_W | Newly computed impedance code |
| ext_res | input | RES_W | External resistor value in ohms |
| upd_stb | output | 1 | Update applied in this cycle |
| drv_code | output | CODE_W | Code feeding the output drivers |
| settled | output | 1 | Power-up settling complete |
| tgt_imp | output | RES_W | Nominal driver impedance in ohms |

## Verification
The bench goes after three corner cases.

- **Starvation.** A long run of output-driving reads is followed by a single read with output-enable off. That one cycle must take the update. A design that restarted or froze its counter during reads would miss it.
- **Spacing.** Runs of exactly `MIN_GAP`-1 and `MIN_GAP` idle cycles expose an off-by-one, which would show up as a strobe one cycle early or late.
- **Settling.** Reads are inserted while the settling count sits one short of its limit. A design that counted reads would assert `settled` early, and one that lost the flag on a later read would drop it.

Resistor values on either side of a multiple of five catch rounding faults in the target impedance.

// File: rtl/imp_upd_sched.sv
module imp_upd_sched #(
  parameter int CODE_W = 6,
  parameter int RES_W = 10,
  parameter int MIN_GAP = 32,
  parameter int SETTLE_CYCLES = 1024,
  parameter logic [CODE_W-1:0] RESET_CODE = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_sel,
  input  logic              cyc_read,
  input  logic              oe_off,
  input  logic [CODE_W-1:0] cal_code,
  input  logic [RES_W-1:0]  ext_res,
  output logic              upd_stb,
  output logic [CODE_W-1:0] drv_code,
  output logic              settled,
  output logic [RES_W-1:0]  tgt_imp
);
  localparam int GW = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
  localparam int NW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP - 1);
  localparam logic [NW-1:0] NR_MAX = NW'(SETTLE_CYCLES);

  logic [GW-1:0] gap_cnt;
  logic [NW-1:0] nr_cnt;
  logic          is_read, drives_out, gap_done;

  assign is_read    = cyc_sel & cyc_read;
  assign drives_out = is_read & ~oe_off;
  assign gap_done   = (gap_cnt == GAP_MAX);
  assign upd_stb    = gap_done & ~drives_out;
  assign settled    = (nr_cnt == NR_MAX);
  assign tgt_imp    = ext_res / RES_W'(5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gap_cnt <= '0;
    else if (upd_stb)
      gap_cnt <= '0;
    else if (!gap_done)
      gap_cnt <= gap_cnt + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      nr_cnt <= '0;
    else if (!is_read && !settled)
      nr_cnt <= nr_cnt + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      drv_code <= RESET_CODE;
    else if (upd_stb)
      drv_code <= cal_code;
  end
endmodule

// File: rtl/imp_upd_sched_chk.sv
module imp_upd_sched_chk #(
  parameter int CODE_W = 6,
  parameter int MIN_GAP = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_sel,
  input logic              cyc_read,
  input logic              oe_off,
  input logic [CODE_W-1:0] cal_code,
  input logic              upd_stb,
  input logic [CODE_W-1:0] drv_code,
  input logic              settled
);
  int since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since <= 0;
    else if (upd_stb)
      since <= 0;
    else if (since < MIN_GAP)
      since <= since + 1;
  end

  a_r2_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> since >= MIN_GAP - 1);

  a_r3_quiet_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_sel && cyc_read && !oe_off) |-> !upd_stb);

  a_r5_no_starve: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= MIN_GAP - 1 && !(cyc_sel && cyc_read && !oe_off)) |-> upd_stb);

  a_r6_code_load: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> drv_code == $past(cal_code));

  a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> $stable(drv_code));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled);
endmodule

bind imp_upd_sched imp_upd_sched_chk #(.CODE_W(CODE_W), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_sel(cyc_sel), .cyc_read(cyc_read),
  .oe_off(oe_off), .cal_code(cal_code), .upd_stb(upd_stb),
  .drv_code(drv_code), .settled(settled)
);

// File: tb/imp_upd_sched_bench.sv
module imp_upd_sched_bench;
  localparam int NROW = 9;
  localparam int T_SEL[NROW] = '{0, 0, 1, 1, 1, 1, 0, 0, 0};
  localparam int T_RD [NROW] = '{0, 0, 1, 1, 0, 1, 0, 0, 0};
  localparam int T_OE [NROW] = '{0, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam int T_LEN[NROW] = '{31, 1, 40, 1, 32, 10, 21, 1, 64};
  localparam int T_STB[NROW] = '{0, 1, 0, 1, 1, 0, 0, 1, 2};

  logic clk = 0;
  logic rst_n = 0;
  logic cyc_sel = 0, cyc_read = 0, oe_off = 0;
  logic [5:0] cal_code = '0;
  logic [9:0] ext_res = '0;
  logic upd_stb, settled;
  logic [5:0] drv_code;
  logic [9:0] tgt_imp;

  int checks = 0, errors = 0, stb_seen = 0, wd = 0;
  logic [5:0] exp_code;

  always #2.5 clk = ~clk;

  imp_upd_sched u_imp_upd_sched (
    .clk(clk), .rst_n(rst_n), .cyc_sel(cyc_sel), .cyc_read(cyc_read),
    .oe_off(oe_off), .cal_code(cal_code), .ext_res(ext_res),
    .upd_stb(upd_stb), .drv_code(drv_code), .settled(settled), .tgt_imp(tgt_imp)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic r, input logic o, input logic [5:0] c);
    cyc_sel = s; cyc_read = r; oe_off = o; cal_code = c;
    #1;
    if (upd_stb) stb_seen++;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_code = 6'h20;
    repeat (3) @(negedge clk);
    check("R1 reset code", drv_code, 6'h20);
    check("R1 reset settled", settled, 0);
    check("R1 reset strobe", upd_stb, 0);
    rst_n = 1;

    for (int i = 0; i < NROW; i++) begin
      logic [5:0] code;
      code = 6'(i * 7 + 3);
      stb_seen = 0;
      for (int k = 0; k < T_LEN[i]; k++)
        cyc(T_SEL[i][0], T_RD[i][0], T_OE[i][0], code);
      if (T_STB[i] > 0) exp_code = code;
      check($sformatf("R2 R3 R4 R5 row %0d strobes", i), stb_seen, T_STB[i]);
      check($sformatf("R6 row %0d code", i), drv_code, exp_code);
    end

    // R7: 150 non-read cycles so far; reach 1023
    check("R7 not yet settled", settled, 0);
    for (int k = 0; k < 873; k++) cyc(0, 0, 0, 6'h11);
    check("R7 one short", settled, 0);
    for (int k = 0; k < 5; k++) cyc(1, 1, 1, 6'h11);
    check("R7 reads not counted", settled, 0);
    cyc(1, 0, 0, 6'h11);
    check("R7 settles", settled, 1);
    for (int k = 0; k < 10; k++) cyc(1, 1, 0, 6'h11);
    check("R7 sticky", settled, 1);

    // R1/R4 after a mid-run reset
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 re-reset code", drv_code, 6'h20);
    check("R1 re-reset settled", settled, 0);
    rst_n = 1;
    stb_seen = 0;
    for (int k = 0; k < 31; k++) cyc(0, 0, 0, 6'h2a);
    check("R4 no early strobe", stb_seen, 0);
    check("R6 code held", drv_code, 6'h20);
    cyc(0, 0, 0, 6'h2a);
    check("R4 strobe at gap", stb_seen, 1);
    check("R6 code loaded", drv_code, 6'h2a);

    // R8 target impedance
    for (int v = 0; v < 6; v++) begin
      int res;
      res = (v == 0) ? 250 : (v == 1) ? 254 : (v == 2) ? 255 :
            (v == 3) ? 0 : (v == 4) ? 1023 : 4;
      ext_res = 10'(res);
      #1;
      check($sformatf("R8 res %0d", res), tgt_imp, res / 5);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule